// File: doc/BRIEF.md
# Three-Port Programmable Parallel Interface

This block is a peripheral with three 8-bit parallel ports. A host reaches it over a small byte bus: an active-low chip select, a 2-bit address, and active-low read and write strobes. Each port bit has an output value and an output enable, so the pad logic drives a pin only when its group is programmed as an output. A pin that is not driven is read back from its input.

A single control word sets the direction of four groups: port A, port B, the upper nibble of port C, and the lower nibble of port C. Every bit in a group takes the same direction. The host can write a new control word at any time to change the directions. Accepting a new control word clears every output latch. A read returns the live pin values for groups set as inputs, and the latched values for groups set as outputs.

The register file is clocked. A write is taken at every rising clock edge on which the chip select and the write strobe are both low. Read data is combinational and is valid while the chip select and the read strobe are both low. Reset is active-low and asynchronous. It sets every group to input.

Top module: `tri_port_pio`

## Requirements
- R1: After reset the control register reads 8'h9B, every output enable is 0 and every output latch is 0.
- R2: addr_i selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. rdata_o is 0 unless cs_ni and rd_ni are both low.
- R3: A control write with bit 7 set is accepted. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the upper nibble of port C and bit 0 sets the lower nibble of port C, with 1 meaning input. Each group's output enables are all 1 when the group is an output and all 0 when it is an input, from the cycle after the write.
- R4: A control write with bit 7 clear changes nothing: the control value, the latches and the enables all stay as they were.
- R5: An accepted control write clears every output latch of all three ports to 0.
- R6: A write to port A, B or C stores the data in that port's latch, whatever the port's direction. The port's output value shows the latch from the cycle after the write.
- R7: A port read returns the pin input for bits in input groups and the latch for bits in output groups. For port C this is decided separately for each nibble.
- R8: A read of the control register returns the last accepted control word.
- R9: A strobe given while cs_ni is high has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A output value |
| pa_oe_o | output | 8 | Port A output enable |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B output value |
| pb_oe_o | output | 8 | Port B output enable |
| pc_i | input | 8 | Port C pin input |
| pc_o | output | 8 | Port C output value |
| pc_oe_o | output | 8 | Port C output enable |

## Verification
A wrong direction bit shows up within one cycle of the control write, as a whole group of output enables with the wrong value. It also makes a port read return the pins when it should return the latch, or the other way round. Latch errors, such as a missed clear on a mode write or a write landing on the wrong port, show at the port outputs on the cycle after the write. The bench checks every output after each bus cycle and compares each read against a model. This catches an accepted word with bit 7 clear, or a write taken with the chip select high, at the first access that follows it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } pio_sel_e;

  localparam int unsigned CW         = 8;
  localparam int unsigned MODE_BIT   = 7;
  localparam int unsigned A_DIR_BIT  = 4;
  localparam int unsigned CU_DIR_BIT = 3;
  localparam int unsigned B_DIR_BIT  = 1;
  localparam int unsigned CL_DIR_BIT = 0;
  localparam logic [CW-1:0] CTRL_RST = 8'h9B;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] ctrl_o,
  output logic          mode_wr_o
);
  logic [CW-1:0] ctrl_q;

  assign mode_wr_o = wr_i && wdata_i[MODE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (mode_wr_o) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;

  // R4: a word without the mode flag leaves the register alone
  a_r4_ignore_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[MODE_BIT]) |=> $stable(ctrl_q));

  // R8: an accepted word is held as written
  a_r8_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_o |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/pio_group.sv
module pio_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_in_i,
  input  logic         wr_en_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= '0;
    else if (clr_i)   latch_q <= '0;
    else if (wr_en_i) latch_q <= wdata_i;
  end

  assign pin_o = latch_q;
  assign oe_o  = {W{~dir_in_i}};
  assign rd_o  = dir_in_i ? pin_i : latch_q;

  // R5: mode write empties the latch
  a_r5_clear_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pin_o == '0));

  // R6: port write lands in the latch
  a_r6_port_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> (pin_o == $past(wdata_i)));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int unsigned NW = DW / 2;

  logic          acc_wr, acc_rd, ctrl_wr, mode_wr;
  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] rd_a, rd_b, rd_c;
  pio_sel_e      sel;

  assign sel     = pio_sel_e'(addr_i);
  assign acc_wr  = !cs_ni && !wr_ni;
  assign acc_rd  = !cs_ni && !rd_ni;
  assign ctrl_wr = acc_wr && (sel == SEL_CTRL);

  pio_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i[CW-1:0]),
    .ctrl_o    (ctrl_q),
    .mode_wr_o (mode_wr)
  );

  pio_group #(.W(DW)) u_grp_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_in_i(ctrl_q[A_DIR_BIT]),
    .wr_en_i(acc_wr && sel == SEL_A), .clr_i(mode_wr), .wdata_i(wdata_i),
    .pin_i(pa_i), .pin_o(pa_o), .oe_o(pa_oe_o), .rd_o(rd_a)
  );

  pio_group #(.W(DW)) u_grp_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_in_i(ctrl_q[B_DIR_BIT]),
    .wr_en_i(acc_wr && sel == SEL_B), .clr_i(mode_wr), .wdata_i(wdata_i),
    .pin_i(pb_i), .pin_o(pb_o), .oe_o(pb_oe_o), .rd_o(rd_b)
  );

  // port C: two nibble groups, lower (g=0) and upper (g=1)
  for (genvar g = 0; g < 2; g++) begin : g_pc
    localparam int unsigned DIR_BIT = (g == 0) ? CL_DIR_BIT : CU_DIR_BIT;
    pio_group #(.W(NW)) u_grp_c (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dir_in_i (ctrl_q[DIR_BIT]),
      .wr_en_i  (acc_wr && sel == SEL_C),
      .clr_i    (mode_wr),
      .wdata_i  (wdata_i[g*NW +: NW]),
      .pin_i    (pc_i[g*NW +: NW]),
      .pin_o    (pc_o[g*NW +: NW]),
      .oe_o     (pc_oe_o[g*NW +: NW]),
      .rd_o     (rd_c[g*NW +: NW])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (acc_rd) begin
      unique case (sel)
        SEL_A:    rdata_o = rd_a;
        SEL_B:    rdata_o = rd_b;
        SEL_C:    rdata_o = rd_c;
        SEL_CTRL: rdata_o = DW'(ctrl_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  // R3: direction bits drive whole-group enables
  a_r3_dir_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pa_oe_o == {DW{~$past(wdata_i[A_DIR_BIT])}}));
  a_r3_dir_cu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pc_oe_o[DW-1:NW] == {NW{~$past(wdata_i[CU_DIR_BIT])}}));

  // R9: deselected strobes change nothing
  a_r9_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(ctrl_q) && $stable(pa_o) && $stable(pb_o) && $stable(pc_o)));

  // R7: output-mode read of A returns what the port drives
  a_r7_read_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && sel == SEL_A && pa_oe_o[0]) |-> (rdata_o == pa_o));
endmodule

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_ctrl, m_a, m_b, m_c;

  always #4 clk = ~clk;

  tri_port_pio u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  function automatic logic [7:0] exp_oe(input int unsigned p);
    case (p)
      0:       return m_ctrl[4] ? 8'h00 : 8'hFF;
      1:       return m_ctrl[1] ? 8'h00 : 8'hFF;
      default: return {m_ctrl[3] ? 4'h0 : 4'hF, m_ctrl[0] ? 4'h0 : 4'hF};
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl[4] ? pa_i : m_a;
      2'd1:    return m_ctrl[1] ? pb_i : m_b;
      2'd2:    return {m_ctrl[3] ? pc_i[7:4] : m_c[7:4], m_ctrl[0] ? pc_i[3:0] : m_c[3:0]};
      default: return m_ctrl;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " R6 pa_o"}, pa_o, m_a);
    chk({tag, " R6 pb_o"}, pb_o, m_b);
    chk({tag, " R6 pc_o"}, pc_o, m_c);
    chk({tag, " R3 pa_oe"}, pa_oe, exp_oe(0));
    chk({tag, " R3 pb_oe"}, pb_oe, exp_oe(1));
    chk({tag, " R3 pc_oe"}, pc_oe, exp_oe(2));
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    if (!sel_n) begin
      case (a)
        2'd0: m_a = d;
        2'd1: m_b = d;
        2'd2: m_c = d;
        default: if (d[7]) begin m_ctrl = d; m_a = '0; m_b = '0; m_c = '0; end
      endcase
    end
    #1;
    chk_ports("after write");
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic sel_n, input string tag);
    @(negedge clk);
    cs_n = sel_n; rd_n = 1'b0; addr = a;
    #1;
    chk(tag, rdata, sel_n ? 8'h00 : exp_rd(a));
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_ctrl = 8'h9B; m_a = '0; m_b = '0; m_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_ports("R1 reset");
    pa_i = 8'h3C; pb_i = 8'hC3; pc_i = 8'hA5;
    bus_rd(2'd3, 1'b0, "R1 R8 reset ctrl");
    bus_rd(2'd0, 1'b0, "R1 R7 reset A reads pins");
    bus_rd(2'd2, 1'b0, "R7 reset C reads pins");

    // all outputs
    bus_wr(2'd3, 8'h80, 1'b0);
    bus_wr(2'd0, 8'h5A, 1'b0);
    bus_wr(2'd1, 8'hE1, 1'b0);
    bus_wr(2'd2, 8'h96, 1'b0);
    bus_rd(2'd0, 1'b0, "R7 A output reads latch");
    bus_rd(2'd1, 1'b0, "R2 R7 B output reads latch");
    bus_rd(2'd2, 1'b0, "R2 R7 C output reads latch");
    bus_rd(2'd3, 1'b0, "R8 ctrl 80");

    // word without mode flag
    bus_wr(2'd3, 8'h1B, 1'b0);
    bus_rd(2'd3, 1'b0, "R4 ctrl unchanged");
    chk("R4 A latch kept", pa_o, 8'h5A);

    // deselected write and read
    bus_wr(2'd0, 8'hFF, 1'b1);
    chk("R9 A unchanged", pa_o, 8'h5A);
    bus_wr(2'd3, 8'h9B, 1'b1);
    bus_rd(2'd3, 1'b0, "R9 ctrl unchanged");
    bus_rd(2'd0, 1'b1, "R2 deselected read zero");

    // mixed: A in, C upper in, C lower in, B out
    bus_wr(2'd3, 8'h99, 1'b0);
    chk("R5 B cleared", pb_o, 8'h00);
    bus_wr(2'd3, 8'h88, 1'b0);
    bus_wr(2'd2, 8'h7E, 1'b0);
    pc_i = 8'h1F;
    bus_rd(2'd2, 1'b0, "R7 C mixed nibbles");
    bus_wr(2'd3, 8'h81, 1'b0);
    chk("R5 C cleared", pc_o, 8'h00);
    bus_rd(2'd2, 1'b0, "R7 C lower input");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic       s;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      s = ($urandom_range(0, 7) == 0);
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      if ($urandom_range(0, 1) == 1) bus_wr(a, d, s);
      else bus_rd(a, s, "R2 R7 R8 random read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule